// File: doc/BRIEF.md
# Gated-Read Integer Register File

This block is a 32-entry, 32-bit integer register file for a single-issue pipeline. It has two array read ports and one array write port. Its control logic keeps the storage array and the operand latches idle whenever their work would not change the result. For each instruction the decode stage supplies a mask of the operands the instruction uses, the two source register numbers, and a flag per source saying whether the bypass network already carries a newer value. The block fills three operand latches: the first source, the second source, and the store data. Each latch updates on the clock edge that ends the issue cycle.

Read port A serves only the first-source latch. Read port B serves both the second-source latch and the store-data latch, and both of those latches take the second source number. Register 0 has no storage cell. Reads of it yield zero through the latch input mux, and writes to it are dropped. If an instruction loads a latch from the same register that the previous instruction used for that latch, the held value is kept. In that case neither the array nor the latch is clocked. All gating is combinational from the decoded inputs, so read timing is the same as in an ungated file.

The array read enables, the write strobe and the latch enables are driven out as ports. The block also keeps running counts of array reads on each port, array writes and latch loads. With these, the energy activity can be compared against a model.

Top module: `gated_regfile`

## Requirements
- R1: Read port A (`rdEnA`) is high only when the first-source operand is needed (`needMask` bit 0), its bypass flag is low, its register number is nonzero, and it cannot be reused. It is high in every such cycle.
- R2: Read port B (`rdEnB`) is high exactly when the second-source latch (`needMask` bit 1) or the store-data latch (`needMask` bit 2) needs a fresh array value under the same conditions as R1, using `srcRt` and `bypHitRt`.
- R3: Each latch enable (`latchEn` bit 0 first source, bit 1 second source, bit 2 store data) is high exactly when the operand is needed and cannot be reused. A latch that is not enabled keeps its value.
- R4: When a needed operand's bypass flag is high, the latch loads the bypass data on the next edge and the array is not read for it.
- R5: A needed operand from register 0 loads zero without an array read.
- R6: A write to register 0 does not raise `wrStrobe` and leaves reads of register 0 at zero. A write to any other register raises `wrStrobe` in that cycle.
- R7: An operand can be reused when all of the following hold for the previous cycle: the same latch was needed, it had no bypass flag, it used the same register number, and no write to that nonzero register took place. The current instruction must also have no bypass flag. A reused operand causes no array read and no latch load, and the latch keeps its value.
- R8: Reuse is cancelled when the previous instruction did not use that latch, when it took the bypass value, or when a write to the held register took place in that cycle.
- R9: After each instruction's edge, every needed operand output equals the value an ungated file would give. That value is the bypass data if the flag is set, otherwise the array contents before that cycle's write, with zero for register 0.
- R10: `cntRdA`, `cntRdB`, `cntWr` and `cntLatch` reset to zero. They add, per cycle, `rdEnA`, `rdEnB`, `wrStrobe` and the number of set `latchEn` bits.
- R11: A write and a read of the same register in one cycle give the old array value. The newer value is only used when the bypass flag says so.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| needMask | input | 3 | Operands used: bit 0 first source, bit 1 second source, bit 2 store data |
| srcRs | input | 5 | First source register number |
| srcRt | input | 5 | Second source register number (also feeds store data) |
| bypHitRs | input | 1 | Bypass supplies the first source |
| bypHitRt | input | 1 | Bypass supplies the second source / store data |
| bypDataRs | input | 32 | Bypass value for the first source |
| bypDataRt | input | 32 | Bypass value for the second source / store data |
| wrEn | input | 1 | Write request |
| wrAddr | input | 5 | Write register number |
| wrData | input | 32 | Write value |
| rdEnA | output | 1 | Array read port A enabled this cycle |
| rdEnB | output | 1 | Array read port B enabled this cycle |
| wrStrobe | output | 1 | Array write performed this cycle |
| latchEn | output | 3 | Latch load enables, same bit order as needMask |
| opRs | output | 32 | First-source latch |
| opRt | output | 32 | Second-source latch |
| opSd | output | 32 | Store-data latch |
| cntRdA | output | 32 | Port A read count |
| cntRdB | output | 32 | Port B read count |
| cntWr | output | 32 | Array write count |
| cntLatch | output | 32 | Latch load count |

## Verification
The assertions assume three things about the inputs:
- The inputs are quiet while reset is held, so the first cycle after reset cannot look like a reuse.
- The bypass flag is the only path for a value written in the same cycle or still in flight.
- The bypass data is valid whenever its flag is set.

The bench drives a zero need mask during reset. It mixes bypass flags, same-cycle writes and register-0 traffic freely, and it compares operands against an ungated model. That model applies exactly the same bypass rule, so no stimulus outside these assumptions is ever scored. Most of the randomized stimulus uses register numbers in a small range so that reuse and write collisions occur often.

// File: rtl/grf_pkg.sv
package grf_pkg;

  localparam int LATCH_N  = 3;
  localparam int LATCH_RS = 0;
  localparam int LATCH_RT = 1;
  localparam int LATCH_SD = 2;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_ZERO   = 2'd2
  } src_e;

  typedef struct packed {
    logic                rdEnA;
    logic                rdEnB;
    logic                wrEn;
    logic [LATCH_N-1:0]  latchEn;
    src_e                selRs;
    src_e                selRt;
    src_e                selSd;
  } grf_strobe_t;

endpackage

// File: rtl/grf_control.sv
module grf_control
  import grf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LATCH_N-1:0] needMask,
  input  logic [AW-1:0]      srcRs,
  input  logic [AW-1:0]      srcRt,
  input  logic               bypHitRs,
  input  logic               bypHitRt,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrAddr,
  output grf_strobe_t        strobe
);

  logic [AW-1:0]      latchAddr [LATCH_N];
  logic [LATCH_N-1:0] latchByp;
  logic [LATCH_N-1:0] reuse;
  logic [LATCH_N-1:0] loadEn;
  logic [LATCH_N-1:0] fresh;
  logic [LATCH_N-1:0] wrHit;
  logic [LATCH_N-1:0] holdValid;
  logic [AW-1:0]      holdTag [LATCH_N];
  src_e               sel [LATCH_N];

  always_comb begin
    for (int i = 0; i < LATCH_N; i++) begin
      latchAddr[i] = (i == LATCH_RS) ? srcRs : srcRt;
      latchByp[i]  = (i == LATCH_RS) ? bypHitRs : bypHitRt;
      reuse[i]     = needMask[i] && !latchByp[i] && holdValid[i] &&
                     (holdTag[i] == latchAddr[i]);
      loadEn[i]    = needMask[i] && !reuse[i];
      if (latchByp[i])               sel[i] = SRC_BYPASS;
      else if (latchAddr[i] == '0)   sel[i] = SRC_ZERO;
      else                           sel[i] = SRC_ARRAY;
      fresh[i]     = loadEn[i] && (sel[i] == SRC_ARRAY);
      wrHit[i]     = wrEn && (wrAddr != '0) && (wrAddr == latchAddr[i]);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.rdEnA   = fresh[LATCH_RS];
    strobe.rdEnB   = fresh[LATCH_RT] | fresh[LATCH_SD];
    strobe.wrEn    = wrEn && (wrAddr != '0);
    strobe.latchEn = loadEn;
    strobe.selRs   = sel[LATCH_RS];
    strobe.selRt   = sel[LATCH_RT];
    strobe.selSd   = sel[LATCH_SD];
  end

  // Reuse tracking: a latch stays reusable only while consecutive
  // instructions use it from the array path and nothing rewrites its register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= '0;
      for (int i = 0; i < LATCH_N; i++) holdTag[i] <= '0;
    end else begin
      for (int i = 0; i < LATCH_N; i++) begin
        holdValid[i] <= needMask[i] && !latchByp[i] && !wrHit[i];
        holdTag[i]   <= latchAddr[i];
      end
    end
  end

  AST_BYP_NO_READ_A: assert property (@(posedge clk) disable iff (!rstN)
    (needMask[LATCH_RS] && bypHitRs) |-> !strobe.rdEnA);  // R4

  AST_ZERO_NO_READ_A: assert property (@(posedge clk) disable iff (!rstN)
    (srcRs == '0) |-> !strobe.rdEnA);  // R5

  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrAddr == '0) |-> !strobe.wrEn);  // R6

  AST_REUSE_SKIP_A: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && needMask[LATCH_RS] && !bypHitRs && (srcRs == $past(srcRs)) &&
     $past(needMask[LATCH_RS] && !bypHitRs &&
           !(wrEn && (wrAddr != '0) && (wrAddr == srcRs))))
    |-> (!strobe.rdEnA && !strobe.latchEn[LATCH_RS]));  // R7

  AST_NO_NEED_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (needMask == '0) |-> (strobe.latchEn == '0 && !strobe.rdEnA && !strobe.rdEnB));  // R3

endmodule

// File: rtl/grf_datapath.sv
module grf_datapath
  import grf_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int AW    = 5,
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  grf_strobe_t                   strobe,
  input  logic [AW-1:0]                 srcRs,
  input  logic [AW-1:0]                 srcRt,
  input  logic [XLEN-1:0]               bypDataRs,
  input  logic [XLEN-1:0]               bypDataRt,
  input  logic [AW-1:0]                 wrAddr,
  input  logic [XLEN-1:0]               wrData,
  output logic [LATCH_N-1:0][XLEN-1:0]  latchQ,
  output logic [CNT_W-1:0]              cntRdA,
  output logic [CNT_W-1:0]              cntRdB,
  output logic [CNT_W-1:0]              cntWr,
  output logic [CNT_W-1:0]              cntLatch
);

  localparam int LOAD_W = $clog2(LATCH_N + 1);

  // Entry 0 is absent: it reads as zero through the latch mux.
  logic [XLEN-1:0] mem [1:NREGS-1];
  logic [XLEN-1:0] rdDataA;
  logic [XLEN-1:0] rdDataB;
  logic [LOAD_W-1:0] loadCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 1; k < NREGS; k++) mem[k] <= '0;
    end else begin
      for (int k = 1; k < NREGS; k++)
        if (strobe.wrEn && (wrAddr == AW'(k))) mem[k] <= wrData;
    end
  end

  always_comb begin
    rdDataA = '0;
    rdDataB = '0;
    for (int k = 1; k < NREGS; k++) begin
      if (strobe.rdEnA && (srcRs == AW'(k))) rdDataA = mem[k];
      if (strobe.rdEnB && (srcRt == AW'(k))) rdDataB = mem[k];
    end
  end

  for (genvar g = 0; g < LATCH_N; g++) begin : gLatch
    src_e            sel;
    logic [XLEN-1:0] arrVal;
    logic [XLEN-1:0] bypVal;
    logic [XLEN-1:0] nextVal;
    logic [XLEN-1:0] q;

    assign sel    = (g == LATCH_RS) ? strobe.selRs :
                    (g == LATCH_RT) ? strobe.selRt : strobe.selSd;
    assign arrVal = (g == LATCH_RS) ? rdDataA : rdDataB;
    assign bypVal = (g == LATCH_RS) ? bypDataRs : bypDataRt;

    always_comb begin
      case (sel)
        SRC_BYPASS: nextVal = bypVal;
        SRC_ARRAY:  nextVal = arrVal;
        default:    nextVal = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 q <= '0;
      else if (strobe.latchEn[g]) q <= nextVal;
    end

    assign latchQ[g] = q;
  end

  always_comb begin
    loadCount = '0;
    for (int i = 0; i < LATCH_N; i++) loadCount = loadCount + LOAD_W'(strobe.latchEn[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntRdA   <= '0;
      cntRdB   <= '0;
      cntWr    <= '0;
      cntLatch <= '0;
    end else begin
      cntRdA   <= cntRdA + CNT_W'(strobe.rdEnA);
      cntRdB   <= cntRdB + CNT_W'(strobe.rdEnB);
      cntWr    <= cntWr + CNT_W'(strobe.wrEn);
      cntLatch <= cntLatch + CNT_W'(loadCount);
    end
  end

  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchEn[LATCH_RS] && strobe.selRs == SRC_ZERO) |=> (latchQ[LATCH_RS] == '0));  // R5

  AST_BYP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchEn[LATCH_RT] && strobe.selRt == SRC_BYPASS)
    |=> (latchQ[LATCH_RT] == $past(bypDataRt)));  // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((cntRdA - $past(cntRdA)) <= 1 && (cntWr - $past(cntWr)) <= 1));  // R10

endmodule

// File: rtl/gated_regfile.sv
module gated_regfile
  import grf_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int CNT_W = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         needMask,
  input  logic [AW-1:0]      srcRs,
  input  logic [AW-1:0]      srcRt,
  input  logic               bypHitRs,
  input  logic               bypHitRt,
  input  logic [XLEN-1:0]    bypDataRs,
  input  logic [XLEN-1:0]    bypDataRt,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrAddr,
  input  logic [XLEN-1:0]    wrData,
  output logic               rdEnA,
  output logic               rdEnB,
  output logic               wrStrobe,
  output logic [2:0]         latchEn,
  output logic [XLEN-1:0]    opRs,
  output logic [XLEN-1:0]    opRt,
  output logic [XLEN-1:0]    opSd,
  output logic [CNT_W-1:0]   cntRdA,
  output logic [CNT_W-1:0]   cntRdB,
  output logic [CNT_W-1:0]   cntWr,
  output logic [CNT_W-1:0]   cntLatch
);

  grf_strobe_t                   strobe;
  logic [LATCH_N-1:0][XLEN-1:0]  latchQ;

  grf_control #(.AW(AW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .needMask (needMask),
    .srcRs    (srcRs),
    .srcRt    (srcRt),
    .bypHitRs (bypHitRs),
    .bypHitRt (bypHitRt),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .strobe   (strobe)
  );

  grf_datapath #(.XLEN(XLEN), .NREGS(NREGS), .AW(AW), .CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcRs     (srcRs),
    .srcRt     (srcRt),
    .bypDataRs (bypDataRs),
    .bypDataRt (bypDataRt),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .latchQ    (latchQ),
    .cntRdA    (cntRdA),
    .cntRdB    (cntRdB),
    .cntWr     (cntWr),
    .cntLatch  (cntLatch)
  );

  assign rdEnA    = strobe.rdEnA;
  assign rdEnB    = strobe.rdEnB;
  assign wrStrobe = strobe.wrEn;
  assign latchEn  = strobe.latchEn;
  assign opRs     = latchQ[LATCH_RS];
  assign opRt     = latchQ[LATCH_RT];
  assign opSd     = latchQ[LATCH_SD];

endmodule

// File: tb/gated_regfile_test.sv
`timescale 1ns/1ps
module gated_regfile_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  needMask = '0;
  logic [4:0]  srcRs = '0, srcRt = '0, wrAddr = '0;
  logic        bypHitRs = 1'b0, bypHitRt = 1'b0, wrEn = 1'b0;
  logic [31:0] bypDataRs = '0, bypDataRt = '0, wrData = '0;
  logic        rdEnA, rdEnB, wrStrobe;
  logic [2:0]  latchEn;
  logic [31:0] opRs, opRt, opSd, cntRdA, cntRdB, cntWr, cntLatch;

  always #2.5 clk = ~clk;

  gated_regfile uut (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  // Bench model: ungated reference values plus gating expectations.
  logic [31:0] refMem [32];
  logic [31:0] mLatch [3];
  logic [2:0]  mValid;
  logic [4:0]  mTag [3];
  logic [31:0] eRdA = 0, eRdB = 0, eWr = 0, eLat = 0;
  logic        sRdA, sRdB, sWr;
  logic [2:0]  sLat;
  logic [31:0] lfsr = 32'hACE1_2357;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic step(input logic [2:0] nm, input logic [4:0] rs, input logic [4:0] rt,
                      input logic bRs, input logic bRt, input logic [31:0] dRs,
                      input logic [31:0] dRt, input logic we, input logic [4:0] wa,
                      input logic [31:0] wd);
    logic [2:0] expLat;
    logic [2:0] fr;
    logic [4:0] addr;
    logic byp;
    logic [2:0] lat;
    @(negedge clk);
    needMask = nm; srcRs = rs; srcRt = rt; bypHitRs = bRs; bypHitRt = bRt;
    bypDataRs = dRs; bypDataRt = dRt; wrEn = we; wrAddr = wa; wrData = wd;
    #1;
    for (int i = 0; i < 3; i++) begin
      addr = (i == 0) ? rs : rt;
      byp  = (i == 0) ? bRs : bRt;
      expLat[i] = nm[i] && !(nm[i] && !byp && mValid[i] && mTag[i] == addr);
      fr[i] = expLat[i] && !byp && addr != 0;
    end
    sRdA = rdEnA; sRdB = rdEnB; sWr = wrStrobe; sLat = latchEn;
    check("R1 port A enable", rdEnA, fr[0]);
    check("R2 port B enable", rdEnB, fr[1] | fr[2]);
    check("R3 latch enables", latchEn, expLat);
    check("R6 write strobe", wrStrobe, we && wa != 0);
    eRdA += fr[0]; eRdB += (fr[1] | fr[2]); eWr += (we && wa != 0);
    eLat += expLat[0] + expLat[1] + expLat[2];
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      addr = (i == 0) ? rs : rt;
      byp  = (i == 0) ? bRs : bRt;
      if (nm[i]) mLatch[i] = byp ? ((i == 0) ? dRs : dRt) : ((addr == 0) ? 32'h0 : refMem[addr]);
      mValid[i] = nm[i] && !byp && !(we && wa != 0 && wa == addr);
      mTag[i] = addr;
    end
    if (we && wa != 0) refMem[wa] = wd;
    #1;
    lat = nm;
    if (lat[0]) check("R9 first source operand", opRs, mLatch[0]);
    if (lat[1]) check("R9 second source operand", opRt, mLatch[1]);
    if (lat[2]) check("R9 store data operand", opSd, mLatch[2]);
  endtask

  task automatic idle();
    step(3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] held;
    for (int k = 0; k < 32; k++) refMem[k] = 0;
    for (int i = 0; i < 3; i++) begin mLatch[i] = 0; mTag[i] = 0; end
    mValid = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset first-source latch", opRs, 0);
    check("R10 reset store latch", opSd, 0);
    check("R10 reset read counter", cntRdA, 0);
    check("R10 reset latch counter", cntLatch, 0);
    @(negedge clk) rstN = 1'b1;

    // R6: write r5, then a write to r0 that must be dropped
    step(3'b000, 0, 0, 0, 0, 0, 0, 1, 5, 32'hA5A5_0001);
    check("R6 nonzero write strobe", sWr, 1);
    step(3'b000, 0, 0, 0, 0, 0, 0, 1, 0, 32'hDEAD_BEEF);
    check("R6 r0 write dropped", sWr, 0);
    // R5: read r0
    step(3'b001, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R5 r0 no array read", sRdA, 0);
    check("R5 r0 reads zero", opRs, 0);
    // R1 then R7 reuse
    step(3'b001, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R1 read of r5", sRdA, 1);
    check("R1 r5 value", opRs, 32'hA5A5_0001);
    step(3'b001, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R7 reuse no read", sRdA, 0);
    check("R7 reuse no latch load", sLat[0], 0);
    check("R7 reuse value", opRs, 32'hA5A5_0001);
    // R11: same-cycle write gives old value; R8: next read refetches
    step(3'b001, 5, 0, 0, 0, 0, 0, 1, 5, 32'h0000_1234);
    check("R11 old value on same-cycle write", opRs, 32'hA5A5_0001);
    step(3'b001, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 write cancels reuse", sRdA, 1);
    check("R8 new value", opRs, 32'h0000_1234);
    // R4 bypass, then R8 after bypass load
    step(3'b001, 5, 0, 1, 0, 32'h77, 0, 0, 0, 0);
    check("R4 bypass no read", sRdA, 0);
    check("R4 bypass value", opRs, 32'h77);
    step(3'b001, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 bypass load cancels reuse", sRdA, 1);
    // R3 hold when unused, R8 after a gap
    held = opRs;
    idle();
    check("R3 unused latch holds", opRs, held);
    step(3'b001, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 gap cancels reuse", sRdA, 1);
    // R2: store needs rt and sd from one port B read
    step(3'b110, 0, 5, 0, 0, 0, 0, 0, 0, 0);
    check("R2 shared port B read", sRdB, 1);
    check("R2 both latches loaded", sLat, 3'b110);
    check("R2 store data value", opSd, 32'h0000_1234);

    // Near-exhaustive mixed traffic over a small register window
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] rs, rt, wa;
      r  = nextRand();
      rs = (r[31:30] == 0) ? r[4:0] : {3'b0, r[1:0]};
      rt = (r[29:28] == 0) ? r[9:5] : {3'b0, r[6:5]};
      wa = {3'b0, r[11:10]};
      step(r[14:12], rs, rt, r[17:16] == 0, r[19:18] == 0, nextRand(), nextRand(),
           r[20], wa, nextRand());
    end
    idle();

    check("R10 port A read count", cntRdA, eRdA);
    check("R10 port B read count", cntRdB, eRdB);
    check("R10 write count", cntWr, eWr);
    check("R10 latch load count", cntLatch, eLat);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule